// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A request carries the virtual address, the kind of access (instruction fetch, data load or data store), the current privilege, the modify-privilege bit with its saved previous-privilege field, the root table page number, the translation mode and the two permission-relaxing bits: supervisor access to user pages and make-executable-readable. The walker accepts one request at a time. It reads table entries through a single request/response memory port and checks the leaf it reaches. When the accessed or dirty bit has to change, it writes the entry back. It then returns one response: a physical address with read, write and execute permission bits, a page fault, or an access fault.

A translation that needs no table (bare mode, or machine privilege after the modify-privilege substitution) is answered in the cycle after acceptance and makes no memory access. Every other translation reads one table entry per level, starting at the top level. Entries are 4 bytes wide and each level is indexed by 10 bits of the virtual page number.

Top module: `sv32_ptw`

## Requirements
- R1: While reset is asserted and after it is released, rsp_valid_o and mem_req_o are low and req_ready_o is high.
- R2: When the mode bit is 0 (bare) or the effective privilege is machine (code 3), the response arrives in the cycle after acceptance with no memory access. It carries rsp_paddr_o equal to the zero-extended virtual address and all three permissions set.
- R3: The effective privilege is req_mpp_i when req_priv_i is machine, req_mprv_i is 1 and the access is not a fetch; otherwise it is req_priv_i. Privilege codes: 0 user, 1 supervisor, 3 machine. Access codes: 0 fetch, 1 load, 2 store (3 is not used).
- R4: A walk reads the top-level entry at root_ppn*4096 + VA[31:22]*4. An entry with V=1 and R=W=X=0 is a pointer: the next read is at PTE[31:10]*4096 + VA[21:12]*4. Entry bits: V=0, R=1, W=2, X=3, U=4, A=6, D=7, PPN=31:10.
- R5: An entry with V=0 gives a page fault. A pointer found at the second level also gives a page fault.
- R6: A leaf whose W bit is set while R is clear (W-only or W+X) gives a page fault.
- R7: A leaf with U=1 faults when the effective privilege is not user and either the supervisor-access bit is clear or the access is a fetch. A leaf with U=0 faults when the effective privilege is not supervisor.
- R8: A top-level leaf whose PTE[19:10] is non-zero is a misaligned superpage and gives a page fault.
- R9: A load needs R, or X together with the executable-readable bit. A store needs W. A fetch needs X. Otherwise the result is a page fault.
- R10: On a permitted leaf, A is set, and D as well for a store. If this changes the entry, the updated value is written to the same address before the response; otherwise no write occurs.
- R11: On success the physical address is {PPN, VA[11:0]} for a second-level leaf and {PTE[31:20], VA[21:0]} for a top-level superpage.
- R12: The reported read permission is R or (X and the executable-readable bit). Execute is X. Write is W only when the access is a store or D is already set. A faulting response reports no permissions.
- R13: A memory response with the error flag, on a read or a write-back, ends the walk with rsp_access_fault_o=1 and rsp_page_fault_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted on valid |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv_i | input | 1 | Modify-privilege for data accesses |
| req_mpp_i | input | 2 | Saved previous privilege |
| req_mode_i | input | 1 | 0 bare, 1 two-level translation |
| req_root_ppn_i | input | 22 | Root table page number |
| req_sum_i | input | 1 | Supervisor may access user pages |
| req_mxr_i | input | 1 | Executable pages readable by loads |
| mem_req_o | output | 1 | Memory access pending, held until response |
| mem_we_o | output | 1 | Pending access is a write |
| mem_addr_o | output | 34 | Entry byte address |
| mem_wdata_o | output | 32 | Write-back entry value |
| mem_rsp_valid_i | input | 1 | Memory response |
| mem_rsp_err_i | input | 1 | Memory response carries an error |
| mem_rdata_i | input | 32 | Entry read data |
| rsp_valid_o | output | 1 | Translation result, one cycle |
| rsp_paddr_o | output | 34 | Physical address |
| rsp_r_o | output | 1 | Read permitted |
| rsp_w_o | output | 1 | Write permitted |
| rsp_x_o | output | 1 | Execute permitted |
| rsp_page_fault_o | output | 1 | Page fault |
| rsp_access_fault_o | output | 1 | Access fault from a memory error |

## Verification
The assertions assume that the memory side answers each pending access exactly once, only while mem_req_o is high, and keeps mem_rdata_i valid during that response cycle. They also assume that the access code is never 3 and that the saved previous-privilege field never holds the reserved code 2. The stimulus draws access kinds only from {0,1,2} and privileges only from {0,1,3}. Its memory model answers one pending access at a time after a random delay of zero to two cycles and reports an error only at the one address or phase chosen for that translation.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_R = 1;
  localparam int unsigned PTE_W = 2;
  localparam int unsigned PTE_X = 3;
  localparam int unsigned PTE_U = 4;
  localparam int unsigned PTE_A = 6;
  localparam int unsigned PTE_D = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } walk_st_e;
endpackage

// File: rtl/sv32_eff_priv.sv
module sv32_eff_priv
  import sv32_walk_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic [1:0] acc_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  output logic [1:0] priv_o
);
  // data accesses in machine mode may borrow the saved privilege
  assign priv_o = (priv_i == PRIV_M && acc_i != ACC_FETCH && mprv_i) ? mpp_i : priv_i;
endmodule

// File: rtl/sv32_leaf_chk.sv
module sv32_leaf_chk
  import sv32_walk_pkg::*;
#(
  parameter int unsigned PTE_BITS = 32,
  parameter int unsigned PPN_W    = 22,
  parameter int unsigned VPN_W    = 10,
  parameter int unsigned LEVELS   = 2,
  parameter int unsigned LVL_W    = 1
) (
  input  logic [PTE_BITS-1:0]     pte_i,
  input  logic [1:0]              acc_i,
  input  logic [1:0]              priv_i,
  input  logic                    sum_i,
  input  logic                    mxr_i,
  input  logic [LVL_W-1:0]        lvl_i,
  input  logic [LEVELS*VPN_W-1:0] vpn_i,
  output logic                    fault_o,
  output logic                    r_o,
  output logic                    w_o,
  output logic                    x_o,
  output logic [PTE_BITS-1:0]     upd_o,
  output logic [PPN_W-1:0]        ppn_o
);
  logic pr, pw, px, pu, pd;
  logic rsv, us_bad, mis, perm_bad;
  logic [PPN_W-1:0] ppn, sp_mask, va_ppn;

  assign pr = pte_i[PTE_R];
  assign pw = pte_i[PTE_W];
  assign px = pte_i[PTE_X];
  assign pu = pte_i[PTE_U];
  assign pd = pte_i[PTE_D];

  assign ppn     = pte_i[PTE_BITS-1 -: PPN_W];
  // low page-number bits covered by a leaf found at level lvl_i
  assign sp_mask = (PPN_W'(1) << (32'(lvl_i) * VPN_W)) - PPN_W'(1);
  assign va_ppn  = PPN_W'(vpn_i);

  assign rsv = pw & ~pr;

  always_comb begin
    if (pu) us_bad = (priv_i != PRIV_U) && (!sum_i || acc_i == ACC_FETCH);
    else    us_bad = (priv_i != PRIV_S);
  end

  assign mis = |(ppn & sp_mask);

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  perm_bad = ~(pr | (px & mxr_i));
      ACC_STORE: perm_bad = ~pw;
      default:   perm_bad = ~px;
    endcase
  end

  assign fault_o = rsv | us_bad | mis | perm_bad;
  assign r_o     = pr | (px & mxr_i);
  assign x_o     = px;
  assign w_o     = pw & ((acc_i == ACC_STORE) | pd);
  assign upd_o   = pte_i | (PTE_BITS'(1) << PTE_A)
                 | ((acc_i == ACC_STORE) ? (PTE_BITS'(1) << PTE_D) : '0);
  assign ppn_o   = ppn | (va_ppn & sp_mask);
endmodule

// File: rtl/sv32_ptw.sv
module sv32_ptw
  import sv32_walk_pkg::*;
#(
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned VPN_W    = 10,
  parameter int unsigned LEVELS   = 2,
  parameter int unsigned PTE_BITS = 32,
  parameter int unsigned PPN_W    = 22
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [OFF_W+LEVELS*VPN_W-1:0] req_vaddr_i,
  input  logic [1:0]                   req_acc_i,
  input  logic [1:0]                   req_priv_i,
  input  logic                         req_mprv_i,
  input  logic [1:0]                   req_mpp_i,
  input  logic                         req_mode_i,
  input  logic [PPN_W-1:0]             req_root_ppn_i,
  input  logic                         req_sum_i,
  input  logic                         req_mxr_i,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [PPN_W+OFF_W-1:0]       mem_addr_o,
  output logic [PTE_BITS-1:0]          mem_wdata_o,
  input  logic                         mem_rsp_valid_i,
  input  logic                         mem_rsp_err_i,
  input  logic [PTE_BITS-1:0]          mem_rdata_i,
  output logic                         rsp_valid_o,
  output logic [PPN_W+OFF_W-1:0]       rsp_paddr_o,
  output logic                         rsp_r_o,
  output logic                         rsp_w_o,
  output logic                         rsp_x_o,
  output logic                         rsp_page_fault_o,
  output logic                         rsp_access_fault_o
);
  localparam int unsigned VA_W  = OFF_W + LEVELS * VPN_W;
  localparam int unsigned PA_W  = PPN_W + OFF_W;
  localparam int unsigned PTE_B = $clog2(PTE_BITS / 8);
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_st_e            state_q;
  logic [VA_W-1:0]     va_q;
  logic [1:0]          acc_q, eff_q;
  logic                sum_q, mxr_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [PPN_W-1:0]    base_q;
  logic [PTE_BITS-1:0] wdata_q;
  logic [1:0]          eff_priv;

  logic                rsp_valid_q, r_q, w_q, x_q, pf_q, af_q;
  logic [PA_W-1:0]     paddr_q;

  logic                leaf_fault, leaf_r, leaf_w, leaf_x;
  logic [PTE_BITS-1:0] leaf_upd;
  logic [PPN_W-1:0]    leaf_ppn;
  logic                is_ptr;

  logic [VPN_W-1:0] vpn_sl [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
    assign vpn_sl[g] = va_q[OFF_W + g*VPN_W +: VPN_W];
  end

  sv32_eff_priv u_eff (
    .priv_i (req_priv_i),
    .acc_i  (req_acc_i),
    .mprv_i (req_mprv_i),
    .mpp_i  (req_mpp_i),
    .priv_o (eff_priv)
  );

  sv32_leaf_chk #(
    .PTE_BITS (PTE_BITS),
    .PPN_W    (PPN_W),
    .VPN_W    (VPN_W),
    .LEVELS   (LEVELS),
    .LVL_W    (LVL_W)
  ) u_leaf (
    .pte_i   (mem_rdata_i),
    .acc_i   (acc_q),
    .priv_i  (eff_q),
    .sum_i   (sum_q),
    .mxr_i   (mxr_q),
    .lvl_i   (lvl_q),
    .vpn_i   (va_q[VA_W-1:OFF_W]),
    .fault_o (leaf_fault),
    .r_o     (leaf_r),
    .w_o     (leaf_w),
    .x_o     (leaf_x),
    .upd_o   (leaf_upd),
    .ppn_o   (leaf_ppn)
  );

  assign is_ptr = ~(mem_rdata_i[PTE_R] | mem_rdata_i[PTE_W] | mem_rdata_i[PTE_X]);

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = {base_q, vpn_sl[lvl_q], PTE_B'(0)};
  assign mem_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      acc_q       <= ACC_FETCH;
      eff_q       <= PRIV_U;
      sum_q       <= 1'b0;
      mxr_q       <= 1'b0;
      lvl_q       <= '0;
      base_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      paddr_q     <= '0;
      r_q         <= 1'b0;
      w_q         <= 1'b0;
      x_q         <= 1'b0;
      pf_q        <= 1'b0;
      af_q        <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q  <= req_vaddr_i;
            acc_q <= req_acc_i;
            eff_q <= eff_priv;
            sum_q <= req_sum_i;
            mxr_q <= req_mxr_i;
            if (!req_mode_i || eff_priv == PRIV_M) begin
              rsp_valid_q <= 1'b1;
              paddr_q     <= PA_W'(req_vaddr_i);
              {r_q, w_q, x_q} <= 3'b111;
              pf_q <= 1'b0;
              af_q <= 1'b0;
            end else begin
              base_q  <= req_root_ppn_i;
              lvl_q   <= TOP_LVL;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_rsp_valid_i) begin
            pf_q <= 1'b0;
            af_q <= 1'b0;
            {r_q, w_q, x_q} <= 3'b000;
            if (mem_rsp_err_i) begin
              rsp_valid_q <= 1'b1;
              af_q        <= 1'b1;
              state_q     <= ST_IDLE;
            end else if (!mem_rdata_i[PTE_V] || (is_ptr && lvl_q == '0)) begin
              rsp_valid_q <= 1'b1;
              pf_q        <= 1'b1;
              state_q     <= ST_IDLE;
            end else if (is_ptr) begin
              base_q <= mem_rdata_i[PTE_BITS-1 -: PPN_W];
              lvl_q  <= lvl_q - LVL_W'(1);
            end else if (leaf_fault) begin
              rsp_valid_q <= 1'b1;
              pf_q        <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              paddr_q <= {leaf_ppn, va_q[OFF_W-1:0]};
              {r_q, w_q, x_q} <= {leaf_r, leaf_w, leaf_x};
              if (leaf_upd != mem_rdata_i) begin
                wdata_q <= leaf_upd;
                state_q <= ST_WRITE;
              end else begin
                rsp_valid_q <= 1'b1;
                state_q     <= ST_IDLE;
              end
            end
          end
        end
        ST_WRITE: begin
          if (mem_rsp_valid_i) begin
            rsp_valid_q <= 1'b1;
            state_q     <= ST_IDLE;
            if (mem_rsp_err_i) begin
              af_q <= 1'b1;
              {r_q, w_q, x_q} <= 3'b000;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o        = rsp_valid_q;
  assign rsp_paddr_o        = paddr_q;
  assign rsp_r_o            = r_q;
  assign rsp_w_o            = w_q;
  assign rsp_x_o            = x_q;
  assign rsp_page_fault_o   = pf_q;
  assign rsp_access_fault_o = af_q;

  // R2
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (!req_mode_i || eff_priv == PRIV_M))
    |=> (rsp_valid_o && rsp_r_o && rsp_w_o && rsp_x_o && !mem_req_o));

  // R4
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R10
  wb_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mem_rsp_valid_i && !mem_rsp_err_i));

  // R10
  wb_sets_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[PTE_A]);

  // R12
  fault_no_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_page_fault_o || rsp_access_fault_o))
    |-> !(rsp_r_o || rsp_w_o || rsp_x_o));

  // R13
  af_from_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_access_fault_o) |-> ($past(mem_rsp_err_i) && !rsp_page_fault_o));
endmodule

// File: tb/sim_sv32_ptw.sv
`timescale 1ns/1ps
module sim_sv32_ptw;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0, req_priv = '0, req_mpp = '0;
  logic        req_mprv = 1'b0, req_mode = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
  logic [21:0] req_root = '0;
  logic        mem_req, mem_we;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_r, rsp_w, rsp_x, rsp_pf, rsp_af;
  logic [33:0] rsp_paddr;

  always #4 clk = ~clk;

  sv32_ptw u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_acc_i(req_acc), .req_priv_i(req_priv),
    .req_mprv_i(req_mprv), .req_mpp_i(req_mpp), .req_mode_i(req_mode),
    .req_root_ppn_i(req_root), .req_sum_i(req_sum), .req_mxr_i(req_mxr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_err_i(mem_rsp_err), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_r_o(rsp_r),
    .rsp_w_o(rsp_w), .rsp_x_o(rsp_x), .rsp_page_fault_o(rsp_pf),
    .rsp_access_fault_o(rsp_af)
  );

  logic [31:0] pmem [logic [33:0]];
  int          n_chk = 0, n_err = 0;
  int          n_rd, n_wr;
  logic [33:0] last_ra;
  logic [31:0] last_wd;
  int          err_sel = 0;     // 0 none, 1 read at err_addr, 2 any write
  logic [33:0] err_addr = '0;
  logic [21:0] root_g;
  logic [31:0] va_g;

  typedef struct {
    logic        pass, pf, af;
    logic [2:0]  rwx;
    logic [33:0] pa;
    int          nrd, nwr;
    logic [31:0] wd;
    logic [33:0] lra;
  } exp_t;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  function automatic exp_t model(input logic [1:0] pv, input logic mp, input logic [1:0] mpp,
                                 input logic md, input logic [1:0] ac,
                                 input logic su, input logic mx);
    exp_t e;
    logic [1:0] eff;
    logic [21:0] base;
    logic [33:0] a;
    logic [31:0] p, up;
    logic r, w, x, u;
    e.pass = 0; e.pf = 0; e.af = 0; e.rwx = 3'b000; e.pa = '0;
    e.nrd = 0; e.nwr = 0; e.wd = '0; e.lra = '0;
    eff = (pv == 2'd3 && ac != 2'd0 && mp) ? mpp : pv;
    if (!md || eff == 2'd3) begin
      e.pass = 1; e.rwx = 3'b111; e.pa = {2'b00, va_g};
      return e;
    end
    base = root_g;
    for (int lv = 1; lv >= 0; lv--) begin
      a = (lv == 1) ? {base, va_g[31:22], 2'b00} : {base, va_g[21:12], 2'b00};
      e.nrd++; e.lra = a;
      if (err_sel == 1 && a == err_addr) begin e.af = 1; return e; end
      p = pmem.exists(a) ? pmem[a] : 32'h0;
      r = p[1]; w = p[2]; x = p[3]; u = p[4];
      if (!p[0]) begin e.pf = 1; return e; end
      if (!r && !w && !x) begin
        if (lv == 0) begin e.pf = 1; return e; end
        base = p[31:10];
        continue;
      end
      if (w && !r) begin e.pf = 1; return e; end
      if (u && eff != 2'd0 && (!su || ac == 2'd0)) begin e.pf = 1; return e; end
      if (!u && eff != 2'd1) begin e.pf = 1; return e; end
      if (lv == 1 && p[19:10] != 10'd0) begin e.pf = 1; return e; end
      if (ac == 2'd1 && !(r || (x && mx))) begin e.pf = 1; return e; end
      if (ac == 2'd2 && !w) begin e.pf = 1; return e; end
      if (ac == 2'd0 && !x) begin e.pf = 1; return e; end
      up = p | 32'h40 | ((ac == 2'd2) ? 32'h80 : 32'h0);
      if (up != p) begin
        e.nwr = 1; e.wd = up;
        if (err_sel == 2) begin e.af = 1; return e; end
      end
      e.rwx = {r || (x && mx), w && (ac == 2'd2 || p[7]), x};
      e.pa = (lv == 1) ? {p[31:20], va_g[21:0]} : {p[31:10], va_g[11:0]};
      return e;
    end
    return e;
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_err = 1'b0;
        if (mem_we) begin
          n_wr++; last_wd = mem_wdata;
          if (err_sel == 2) mem_rsp_err = 1'b1;
          else pmem[mem_addr] = mem_wdata;
          mem_rdata = '0;
        end else begin
          n_rd++; last_ra = mem_addr;
          mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
          if (err_sel == 1 && mem_addr == err_addr) mem_rsp_err = 1'b1;
        end
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err = 1'b0;
      end
    end
  end

  task automatic run(input string tag, input logic [1:0] pv, input logic mp, input logic [1:0] mpp,
                     input logic md, input logic [1:0] ac, input logic su, input logic mx);
    exp_t e;
    int cyc;
    e = model(pv, mp, mpp, md, ac, su, mx);
    n_rd = 0; n_wr = 0; last_ra = '0; last_wd = '0;
    @(negedge clk);
    req_vaddr = va_g; req_root = root_g; req_priv = pv; req_mprv = mp; req_mpp = mpp;
    req_mode = md; req_acc = ac; req_sum = su; req_mxr = mx; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 300) begin @(negedge clk); cyc++; end
    if (cyc >= 300) begin
      n_chk++; n_err++;
      $display("FAIL %s no response act=none exp=response", tag);
      return;
    end
    chk({tag, " pf"}, 64'(rsp_pf), 64'(e.pf));
    chk({tag, " af"}, 64'(rsp_af), 64'(e.af));
    chk({tag, " rwx"}, 64'({rsp_r, rsp_w, rsp_x}), 64'(e.rwx));
    if (!e.pf && !e.af) chk({tag, " paddr"}, 64'(rsp_paddr), 64'(e.pa));
    chk({tag, " reads"}, 64'(n_rd), 64'(e.nrd));
    if (e.nrd > 0) chk({tag, " read addr"}, 64'(last_ra), 64'(e.lra));
    chk({tag, " writes"}, 64'(n_wr), 64'(e.nwr));
    if (e.nwr > 0) chk({tag, " wdata"}, 64'(last_wd), 64'(e.wd));
    if (e.pass) chk({tag, " latency"}, 64'(cyc), 64'd0);
  endtask

  task automatic setup(input logic [21:0] rt, input logic [31:0] va,
                       input logic [31:0] p1, input logic [31:0] p2);
    pmem.delete();
    root_g = rt; va_g = va; err_sel = 0; err_addr = '0;
    pmem[{rt, va[31:22], 2'b00}] = p1;
    pmem[{rt + 22'd1, va[21:12], 2'b00}] = p2;
  endtask

  localparam logic [7:0] V = 8'h01, R = 8'h02, W = 8'h04, X = 8'h08, U = 8'h10,
                         A = 8'h40, D = 8'h80;
  localparam logic [21:0] RT = 22'h00100;
  localparam logic [31:0] VA = 32'h1234_5678;

  initial begin
    logic [31:0] ptr;
    void'($urandom(32'd7));
    ptr = mk_pte(RT + 22'd1, V);

    // R1
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 mem_req in reset", 64'(mem_req), 64'd0);
    chk("R1 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);

    // R2
    setup(RT, VA, ptr, mk_pte(22'h00abc, V|R|A|D));
    run("R2 bare", 2'd1, 0, 2'd0, 0, 2'd1, 0, 0);
    run("R2 machine", 2'd3, 0, 2'd0, 1, 2'd2, 0, 0);
    // R3
    setup(RT, VA, ptr, mk_pte(22'h31234, V|R|A));
    run("R3 mprv load as S", 2'd3, 1, 2'd1, 1, 2'd1, 0, 0);
    run("R3 mprv fetch stays M", 2'd3, 1, 2'd0, 1, 2'd0, 0, 0);
    // R4 R11
    setup(RT, VA, ptr, mk_pte(22'h00abc, V|R|W|X|U|A|D));
    run("R4 two-level walk", 2'd0, 0, 2'd0, 1, 2'd1, 0, 0);
    run("R11 page paddr", 2'd0, 0, 2'd0, 1, 2'd2, 0, 0);
    // R5
    setup(RT, VA, 32'h0, 32'h0);
    run("R5 invalid top", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    setup(RT, VA, ptr, mk_pte(22'h00555, V));
    run("R5 pointer at last level", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    // R6
    setup(RT, VA, ptr, mk_pte(22'h00555, V|W|U|A|D));
    run("R6 write-only", 2'd0, 0, 2'd0, 1, 2'd2, 0, 0);
    setup(RT, VA, ptr, mk_pte(22'h00555, V|W|X|U|A|D));
    run("R6 write-exec", 2'd0, 0, 2'd0, 1, 2'd0, 0, 0);
    // R7
    setup(RT, VA, ptr, mk_pte(22'h00777, V|R|X|U|A));
    run("R7 user page sum0", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    run("R7 user page sum1", 2'd1, 0, 2'd0, 1, 2'd1, 1, 0);
    run("R7 user page fetch sum1", 2'd1, 0, 2'd0, 1, 2'd0, 1, 0);
    setup(RT, VA, ptr, mk_pte(22'h00777, V|R|X|A));
    run("R7 sup page from user", 2'd0, 0, 2'd0, 1, 2'd1, 0, 0);
    // R8 R11
    setup(RT, VA, mk_pte(22'h00401, V|R|A), 32'h0);
    run("R8 misaligned superpage", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    setup(RT, VA, mk_pte(22'h12c00, V|R|A), 32'h0);
    run("R11 superpage paddr", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    // R9 R12
    setup(RT, VA, ptr, mk_pte(22'h00999, V|X|A));
    run("R9 load exec-only mxr0", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    run("R12 load exec-only mxr1", 2'd1, 0, 2'd0, 1, 2'd1, 0, 1);
    setup(RT, VA, ptr, mk_pte(22'h00999, V|R|A));
    run("R9 store read-only", 2'd1, 0, 2'd0, 1, 2'd2, 0, 0);
    run("R9 fetch read-only", 2'd1, 0, 2'd0, 1, 2'd0, 0, 0);
    // R10
    setup(RT, VA, ptr, mk_pte(22'h00aaa, V|R|W|A|D));
    run("R10 no write when set", 2'd1, 0, 2'd0, 1, 2'd2, 0, 0);
    setup(RT, VA, ptr, mk_pte(22'h00aaa, V|R|W));
    run("R10 store sets A and D", 2'd1, 0, 2'd0, 1, 2'd2, 0, 0);
    setup(RT, VA, ptr, mk_pte(22'h00aaa, V|R));
    run("R10 load sets A", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    // R12
    setup(RT, VA, ptr, mk_pte(22'h00bbb, V|R|W|A));
    run("R12 load clean page", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    setup(RT, VA, ptr, mk_pte(22'h00bbb, V|R|W|A|D));
    run("R12 load dirty page", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    // R13
    setup(RT, VA, ptr, mk_pte(22'h00ccc, V|R|A));
    err_sel = 1; err_addr = {RT, VA[31:22], 2'b00};
    run("R13 read error", 2'd1, 0, 2'd0, 1, 2'd1, 0, 0);
    setup(RT, VA, ptr, mk_pte(22'h00ccc, V|R|W));
    err_sel = 2;
    run("R13 write-back error", 2'd1, 0, 2'd0, 1, 2'd2, 0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] pvs [3];
      logic [7:0] f1, f2;
      logic [21:0] p1n;
      logic [31:0] p1, p2;
      int k;
      pvs[0] = 2'd0; pvs[1] = 2'd1; pvs[2] = 2'd3;
      root_g = 22'($urandom); va_g = $urandom;
      f1 = 8'($urandom); f1[0] = ($urandom % 10) != 0;
      p1n = 22'($urandom);
      if ($urandom % 10 < 7) p1n[9:0] = '0;
      if ($urandom % 10 < 4) p1 = mk_pte(root_g + 22'd1, {f1[7:4], 3'b000, 1'b1});
      else p1 = mk_pte(p1n, f1);
      f2 = 8'($urandom); f2[0] = ($urandom % 10) != 0;
      p2 = mk_pte(22'($urandom), f2);
      setup(root_g, va_g, p1, p2);
      k = $urandom % 10;
      if (k == 0) begin err_sel = 1; err_addr = {root_g, va_g[31:22], 2'b00}; end
      else if (k == 1) err_sel = 2;
      else if (k == 2) begin err_sel = 1; err_addr = {root_g + 22'd1, va_g[21:12], 2'b00}; end
      run("R4/R9/R11 random", pvs[$urandom % 3], 1'($urandom), pvs[$urandom % 3],
          ($urandom % 8) != 0, 2'($urandom % 3), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule